// File: doc/BRIEF.md
# SD Command Path Sequencer

This block drives one SD/MMC command onto the card's CMD line and then collects the card's reply. It works one bit per clock. The clock is taken to be the card clock already, so clock division happens elsewhere. A one-cycle start strobe latches four things: the 6-bit command index, the 32-bit argument, whether a reply is expected, and whether that reply is long. The block then shifts out the 48-bit frame, MSB first, with a CRC7 that it computes on the fly.

If a reply is expected, the block releases the line and watches for a start bit. It shifts in a 48-bit or 136-bit reply and checks its CRC7. The outcome goes to exactly one of four sticky completion flags: sent, response-end, CRC-fail or timeout. These flags hold until the next accepted command. A fifth flag, active, covers the whole transaction. Host logic pulses start, waits for active to fall, and then reads the flags and the captured reply.

Top module: `sdcmd_seq`

## Requirements
- R1: After reset the block is idle: active low, all four completion flags low, cmd_oe_o low and cmd_out_o high. Whenever cmd_oe_o is low, cmd_out_o is high.
- R2: A start pulse accepted while idle makes the block drive cmd_oe_o high for exactly 48 consecutive cycles, beginning the cycle after the pulse. The frame is sent MSB first: a 0, then a 1, then the index (6 bits), the argument (32 bits), the CRC7 (7 bits) and a final 1.
- R3: The sent CRC7 is the remainder of the first 40 frame bits times x^7, divided by x^7+x^3+1. Index 0 with argument 0 gives a last frame byte of 0x95. Index 17 with argument 0 gives 0x55.
- R4: When no reply is expected, sent_o rises and active_o falls in the cycle right after the final 1 bit.
- R5: active_o is high from the cycle after an accepted start until the cycle in which a completion flag rises. This includes the whole wait for the reply and the reply itself.
- R6: A short reply is 48 bits. Its CRC7 covers its first 40 bits, and the CRC7 field is its bits 40 to 46. A long reply is 136 bits. Its CRC7 covers bits 8 to 127, and the CRC7 field is bits 128 to 134. When the CRC7 field matches, resp_end_o is set. resp_o then holds the whole reply with its last bit in resp_o[0]: a short reply sits in resp_o[47:0] with zeros above, and a long reply fills resp_o[135:0].
- R7: When the received CRC7 field does not match, crc_fail_o is set instead of resp_end_o. resp_o is still updated.
- R8: After the final 1 bit, the block samples cmd_in_i for a low start bit. A low on the 64th sample is still accepted. If 64 samples in a row are high, timeout_o is set and active_o falls on that 64th sample.
- R9: For a long reply, the first 8 bits (start, direction and six reserved bits) do not affect the CRC result. Changing the reserved bits still leads to resp_end_o.
- R10: Accepting a start clears all four completion flags in the same cycle that active_o rises. A start pulse while active is ignored, and the frame in flight is unchanged.
- R11: At most one completion flag is high at any time. Exactly one becomes high when active_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| resp_en_i | input | 1 | A reply is expected |
| resp_long_i | input | 1 | The reply is 136 bits (otherwise 48) |
| cmd_in_i | input | 1 | CMD line as seen from the card side |
| cmd_out_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD line drive enable |
| resp_o | output | 136 | Last captured reply |
| sent_o | output | 1 | Command without reply finished |
| resp_end_o | output | 1 | Reply received with good CRC |
| crc_fail_o | output | 1 | Reply received with bad CRC |
| timeout_o | output | 1 | No reply start bit in the window |
| active_o | output | 1 | Transaction in progress |

## Verification
The assertions assume a few things about the inputs. cmd_in_i is a clean, synchronous bit stream that changes only between rising edges. start_i is a pulse. The command fields hold their values in the cycle the pulse is sampled. They do not assume any particular reply content. The bench drives all inputs on falling edges and sends each reply bit for one cycle. It keeps cmd_in_i high whenever no reply is being sent, so that no start bit is seen by accident. Its only busy-time start pulse comes with changed fields, to show that they are ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int unsigned IDX_W    = 6;
    localparam int unsigned ARG_W    = 32;
    localparam int unsigned CRC_W    = 7;
    localparam int unsigned HDR_W    = 2 + IDX_W + ARG_W;          // bits covered by the TX CRC
    localparam int unsigned FRAME_W  = HDR_W + CRC_W + 1;          // 48
    localparam int unsigned LONG_W   = 136;
    localparam int unsigned LONG_SKIP = 8;                         // leading bits outside the long CRC
    localparam int unsigned RESP_W   = LONG_W;
    localparam int unsigned CNT_W    = $clog2(RESP_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX
    } seq_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
    parameter int unsigned W    = 7,
    parameter logic [W-1:0] POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = bit_i ^ crc_q[W-1];
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = '0;
        end else if (en_i) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int unsigned TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST_VAL = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = tick_i && (cnt_q == LAST_VAL);
        cnt_d  = cnt_q;
        if (clr_i)                      cnt_d = '0;
        else if (tick_i && !last_o)     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic [ARG_W-1:0]  cmd_arg_i,
    input  logic              resp_en_i,
    input  logic              resp_long_i,
    input  logic              cmd_in_i,
    output logic              cmd_out_o,
    output logic              cmd_oe_o,
    output logic [RESP_W-1:0] resp_o,
    output logic              sent_o,
    output logic              resp_end_o,
    output logic              crc_fail_o,
    output logic              timeout_o,
    output logic              active_o
);
    localparam logic [CNT_W-1:0] HDR_END   = CNT_W'(HDR_W);          // first CRC bit index
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CRC_TOP   = CNT_W'(HDR_W + CRC_W - 1);
    localparam logic [CNT_W-1:0] SH_LAST   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LG_LAST   = CNT_W'(LONG_W - 1);
    localparam logic [CNT_W-1:0] LG_LO     = CNT_W'(LONG_SKIP);
    localparam logic [CNT_W-1:0] LG_HI     = CNT_W'(LONG_W - CRC_W - 2);
    localparam logic [CNT_W-1:0] SH_HI     = CNT_W'(HDR_W - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  txsh;
        logic              want_r;
        logic              long_r;
        logic [RESP_W-1:0] rxsh;
        logic [RESP_W-1:0] resp;
        logic              sent;
        logic              rend;
        logic              cfail;
        logic              tout;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              crc_clr, crc_en, crc_bit;
    logic [CRC_W-1:0]  crc_val;
    logic              tmr_clr, tmr_tick, tmr_last;
    logic              out_bit, out_en;
    logic [CNT_W-1:0]  crc_pos;
    logic [RESP_W-1:0] rx_next;
    logic              in_crc_span;
    logic              rx_done;

    sdcmd_crc7 #(.W(CRC_W), .POLY(7'h09)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .en_i  (crc_en),
        .bit_i (crc_bit),
        .crc_o (crc_val)
    );

    sdcmd_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (tmr_tick),
        .last_o (tmr_last)
    );

    always_comb begin
        r_d         = r_q;
        crc_clr     = 1'b0;
        crc_en      = 1'b0;
        crc_bit     = 1'b0;
        tmr_clr     = 1'b0;
        tmr_tick    = 1'b0;
        out_bit     = 1'b1;
        out_en      = 1'b0;
        crc_pos     = CRC_TOP - r_q.cnt;
        rx_next     = {r_q.rxsh[RESP_W-2:0], cmd_in_i};
        in_crc_span = r_q.long_r ? ((r_q.cnt >= LG_LO) && (r_q.cnt <= LG_HI))
                                 : (r_q.cnt <= SH_HI);
        rx_done     = r_q.long_r ? (r_q.cnt == LG_LAST) : (r_q.cnt == SH_LAST);

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_TX;
                    r_d.cnt    = '0;
                    r_d.txsh   = {2'b01, cmd_idx_i, cmd_arg_i};
                    r_d.want_r = resp_en_i;
                    r_d.long_r = resp_long_i;
                    r_d.rxsh   = '0;
                    r_d.sent   = 1'b0;
                    r_d.rend   = 1'b0;
                    r_d.cfail  = 1'b0;
                    r_d.tout   = 1'b0;
                    crc_clr    = 1'b1;
                end
            end

            ST_TX: begin
                out_en  = 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt < HDR_END) begin
                    out_bit  = r_q.txsh[HDR_W-1];
                    crc_en   = 1'b1;
                    crc_bit  = r_q.txsh[HDR_W-1];
                    r_d.txsh = {r_q.txsh[HDR_W-2:0], 1'b0};
                end else if (r_q.cnt < TX_LAST) begin
                    out_bit = crc_val[crc_pos[2:0]];
                end else begin
                    out_bit = 1'b1;
                end
                if (r_q.cnt == TX_LAST) begin
                    crc_clr = 1'b1;
                    tmr_clr = 1'b1;
                    if (r_q.want_r) begin
                        r_d.st = ST_WAIT;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.sent = 1'b1;
                    end
                end
            end

            ST_WAIT: begin
                tmr_tick = cmd_in_i;
                if (!cmd_in_i) begin
                    r_d.st   = ST_RX;
                    r_d.cnt  = CNT_W'(1);
                    r_d.rxsh = rx_next;
                    crc_en   = !r_q.long_r;
                    crc_bit  = 1'b0;
                end else if (tmr_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.tout = 1'b1;
                end
            end

            ST_RX: begin
                r_d.rxsh = rx_next;
                crc_en   = in_crc_span;
                crc_bit  = cmd_in_i;
                if (rx_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.resp = rx_next;
                    if (r_q.rxsh[CRC_W-1:0] == crc_val) r_d.rend  = 1'b1;
                    else                                 r_d.cfail = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q    <= r_d;
        end
    end

    assign cmd_out_o  = out_bit;
    assign cmd_oe_o   = out_en;
    assign resp_o     = r_q.resp;
    assign sent_o     = r_q.sent;
    assign resp_end_o = r_q.rend;
    assign crc_fail_o = r_q.cfail;
    assign timeout_o  = r_q.tout;
    assign active_o   = (r_q.st != ST_IDLE);
endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cmd_out_o,
    input logic cmd_oe_o,
    input logic sent_o,
    input logic resp_end_o,
    input logic crc_fail_o,
    input logic timeout_o,
    input logic active_o
);
    logic [3:0] flags;
    assign flags = {sent_o, resp_end_o, crc_fail_o, timeout_o};

    // R1: released line idles high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe_o |-> cmd_out_o);

    // R2: driving happens only inside a transaction
    a_r2_drive_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe_o |-> active_o);

    // R2: the last driven bit is the end bit
    a_r2_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe_o) |-> $past(cmd_out_o));

    // R5: an accepted start raises active
    a_r5_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !active_o) |=> active_o);

    // R10: flags are clear when a transaction begins
    a_r10_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> (flags == 4'b0000));

    // R11: at most one completion flag
    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // R11: completion produces exactly one flag
    a_r11_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> ($countones(flags) == 1));
endmodule

bind sdcmd_seq sdcmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmd_out_o  (cmd_out_o),
    .cmd_oe_o   (cmd_oe_o),
    .sent_o     (sent_o),
    .resp_end_o (resp_end_o),
    .crc_fail_o (crc_fail_o),
    .timeout_o  (timeout_o),
    .active_o   (active_o)
);

// File: tb/tb_sdcmd_seq.sv
module tb_sdcmd_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [5:0]   cmd_idx_i = '0;
    logic [31:0]  cmd_arg_i = '0;
    logic         resp_en_i = 1'b0;
    logic         resp_long_i = 1'b0;
    logic         cmd_in_i = 1'b1;
    logic         cmd_out_o, cmd_oe_o;
    logic [135:0] resp_o;
    logic         sent_o, resp_end_o, crc_fail_o, timeout_o, active_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdcmd_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
        .cmd_arg_i(cmd_arg_i), .resp_en_i(resp_en_i), .resp_long_i(resp_long_i),
        .cmd_in_i(cmd_in_i), .cmd_out_o(cmd_out_o), .cmd_oe_o(cmd_oe_o),
        .resp_o(resp_o), .sent_o(sent_o), .resp_end_o(resp_end_o),
        .crc_fail_o(crc_fail_o), .timeout_o(timeout_o), .active_o(active_o)
    );

    task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int n);
        logic [6:0] r;
        r = '0;
        for (int i = hi; i > hi - n; i--) begin
            logic t;
            t = r[6] ^ v[i];
            r = {r[5:0], 1'b0};
            if (t) r = r ^ 7'h09;
        end
        return r;
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h;
        h = {2'b01, idx, arg};
        return {h, ref_crc({96'b0, h}, 39, 40), 1'b1};
    endfunction

    function automatic logic [3:0] flags();
        return {sent_o, resp_end_o, crc_fail_o, timeout_o};
    endfunction

    // Sends one command and checks the frame on the line (R2, R3, R5, R10).
    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit want,
                            input bit lng, input bit poke_busy, output logic [47:0] got);
        logic [47:0] exp;
        bit oe_ok, act_ok;
        exp = cmd_frame(idx, arg);
        @(negedge clk);
        cmd_idx_i = idx; cmd_arg_i = arg; resp_en_i = want; resp_long_i = lng; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(flags() == 4'b0, "R10 flags cleared on start", flags(), 0);
        oe_ok = 1'b1; act_ok = 1'b1; got = '0;
        for (int i = 0; i < 48; i++) begin
            got[47-i] = cmd_out_o;
            if (!cmd_oe_o) oe_ok = 1'b0;
            if (!active_o) act_ok = 1'b0;
            if (poke_busy && i == 10) begin
                start_i = 1'b1; cmd_idx_i = ~idx; cmd_arg_i = ~arg; resp_en_i = ~want;
            end
            if (poke_busy && i == 11) start_i = 1'b0;
            @(negedge clk);
        end
        chk(oe_ok, "R2 drive enable for 48 cycles", oe_ok, 1);
        chk(!cmd_oe_o && cmd_out_o, "R2 line released high after frame", {cmd_oe_o, cmd_out_o}, 2'b01);
        chk(act_ok, "R5 active during transmit", act_ok, 1);
        chk(got == exp, poke_busy ? "R10 frame unchanged by busy start" : "R2 R3 frame content", got, exp);
    endtask

    task automatic drive_bits(input logic [135:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            cmd_in_i = v[k];
            @(negedge clk);
        end
        cmd_in_i = 1'b1;
    endtask

    task automatic t_reset();
        chk(!active_o, "R1 active low after reset", active_o, 0);
        chk(flags() == 4'b0, "R1 flags low after reset", flags(), 0);
        chk(!cmd_oe_o && cmd_out_o, "R1 line idle high", {cmd_oe_o, cmd_out_o}, 2'b01);
    endtask

    task automatic t_no_resp(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] last_byte);
        logic [47:0] got;
        send_cmd(idx, arg, 1'b0, 1'b0, 1'b0, got);
        chk(got[7:0] == last_byte, "R3 known CRC byte", got[7:0], last_byte);
        chk(flags() == 4'b1000, "R4 sent flag only", flags(), 4'b1000);
        chk(!active_o, "R4 active falls after end bit", active_o, 0);
    endtask

    task automatic t_short(input logic [5:0] idx, input logic [31:0] arg, input int delay, input bit bad);
        logic [47:0] got, rf;
        logic [6:0]  c;
        send_cmd(idx, arg, 1'b1, 1'b0, 1'b0, got);
        chk(active_o && flags() == 4'b0, "R5 active while awaiting reply", {active_o, flags()}, 5'b10000);
        c  = ref_crc({96'b0, 2'b00, idx, arg}, 39, 40);
        rf = {2'b00, idx, arg, c ^ {6'b0, bad}, 1'b1};
        repeat (delay) @(negedge clk);
        drive_bits({88'b0, rf}, 48);
        chk(!active_o, "R5 active falls at reply end", active_o, 0);
        if (bad)
            chk(flags() == 4'b0010, "R7 crc fail on short reply", flags(), 4'b0010);
        else
            chk(flags() == 4'b0100, "R6 resp end on short reply", flags(), 4'b0100);
        chk(resp_o == {88'b0, rf}, bad ? "R7 reply captured" : "R6 short reply captured", resp_o, {88'b0, rf});
    endtask

    task automatic t_long(input logic [5:0] rsv, input logic [31:0] seed, input bit bad);
        logic [47:0]  got;
        logic [119:0] body;
        logic [6:0]   c;
        logic [135:0] rf;
        send_cmd(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, got);
        body = {seed, ~seed, seed ^ 32'hA5C3_0F96, seed[23:0]};
        c    = ref_crc({8'b0, body, 8'b0}, 127, 120);
        rf   = {2'b00, rsv, body, c ^ {6'b0, bad}, 1'b1};
        repeat (5) @(negedge clk);
        drive_bits(rf, 136);
        if (bad)
            chk(flags() == 4'b0010, "R7 crc fail on long reply", flags(), 4'b0010);
        else
            chk(flags() == 4'b0100, (rsv == 6'h3F) ? "R6 resp end on long reply"
                                                   : "R9 reserved bits outside CRC", flags(), 4'b0100);
        chk(resp_o == rf, "R6 long reply captured", resp_o, rf);
    endtask

    task automatic t_timeout();
        logic [47:0] got;
        send_cmd(6'd8, 32'h0000_01AA, 1'b1, 1'b0, 1'b0, got);
        repeat (63) @(negedge clk);
        chk(active_o && !timeout_o, "R8 still waiting after 63 samples", {active_o, timeout_o}, 2'b10);
        @(negedge clk);
        chk(flags() == 4'b0001, "R8 timeout flag after 64 samples", flags(), 4'b0001);
        chk(!active_o, "R8 active falls on timeout", active_o, 0);
    endtask

    task automatic t_busy_start();
        logic [47:0] got;
        send_cmd(6'd55, 32'hDEAD_0001, 1'b0, 1'b0, 1'b1, got);
        chk(flags() == 4'b1000, "R10 busy start ignored, single completion", flags(), 4'b1000);
        repeat (3) @(negedge clk);
        chk(!active_o && !cmd_oe_o, "R10 no second transaction", {active_o, cmd_oe_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_resp(6'd0, 32'h0, 8'h95);
        t_no_resp(6'd17, 32'h0, 8'h55);
        t_short(6'd3, 32'h1234_5678, 2, 1'b0);
        t_short(6'd13, 32'hFFFF_0000, 63, 1'b0);   // R8 boundary: start bit on 64th sample
        t_short(6'd7, 32'h0F0F_A5A5, 0, 1'b1);
        t_timeout();
        t_long(6'h3F, 32'hC001_BEEF, 1'b0);
        t_long(6'h00, 32'h1357_9BDF, 1'b0);
        t_long(6'h3F, 32'h2468_ACE0, 1'b1);
        t_busy_start();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule